// File: doc/BRIEF.md
# Flash Word-Program and Block-Erase Engine

This block executes the long-running half of a flash command set. After a command decoder has recognised a full sequence, it presents one operation to the engine for one cycle: a word program, an erase of one block, or an erase of the whole array. The operation comes with a word address and, for a program, a data word. The engine owns a small word array that is split into equal blocks. Each block can be write-protected through an input mask, and a single override input lifts every protection at once.

While an operation runs, the engine pulls an active-low busy line and raises a status-visible flag. Reads of the array then return a status word instead of stored data. Programming can only clear bits. A program that asks for a 1 where the cell already holds 0 ends in an error state. That state keeps status on the read port until an abort request arrives. An abort also stops a block or chip erase part-way, and the affected blocks are left holding a fill pattern that marks them invalid. Durations are parameters counted in clock cycles.

Top module: `flash_exec_engine`

## Requirements
- R1: After reset every array word reads all ones, `busy_n` is 1, `status_vis` is 0, and `st_done` and `st_err` are 0.
- R2: A program operation (`op_kind` = 0) leaves the addressed word equal to its previous value ANDed with `op_data`. No other word changes.
- R3: A program or block erase (`op_kind` = 1) whose target block has its `prot_mask` bit set while `unprot_all` is 0 is dropped. `busy_n` stays 1, `status_vis` stays 0, no error is raised and the array is unchanged. The block index is the top log2(NUM_BLOCKS) bits of `op_addr`.
- R4: While `unprot_all` is 1, program and erase act on every block whatever `prot_mask` holds.
- R5: An accepted program holds `busy_n` low for exactly PROG_CYC cycles and an accepted erase for exactly ERASE_CYC cycles, counted from the accepting edge. A successful finish returns to read mode with `st_done` = 1.
- R6: While a program runs, `op_valid` and `abort_req` have no effect. Its duration and result are unchanged.
- R7: While `status_vis` is 1, `rd_data` carries the status word. Bit 0 is done, bit 1 is error, bit 2 is an operation in progress, bit 3 is an abort in progress, and all other bits are 0.
- R8: A program whose data has a 1 where the old word holds 0 still stores old AND data. It then sets `st_err`, keeps `busy_n` low and keeps status visible until `abort_req`. The abort then runs for ABORT_CYC cycles and returns to read mode with `st_err` = 0.
- R9: A block erase sets every word of the target block to all ones. A whole-array erase (`op_kind` = 2) does the same for each block that is open when it is accepted and leaves protected blocks untouched. It is dropped if no block is open.
- R10: `abort_req` during an erase keeps `busy_n` low for ABORT_CYC cycles from the abort edge. Every word of the blocks being erased reads ABORT_FILL afterwards, and `st_done` and `st_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | One-cycle operation request from the command decoder |
| op_kind | input | 2 | 0 program, 1 block erase, 2 whole-array erase, 3 no operation |
| op_addr | input | ADDR_W | Word address; the top bits select the block |
| op_data | input | WORD_W | Data for a program |
| abort_req | input | 1 | Reset command: cancels an erase or clears an error |
| prot_mask | input | NUM_BLOCKS | Per-block write protection, 1 = protected |
| unprot_all | input | 1 | Overrides all protection while high |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | WORD_W | Array word in read mode, status word otherwise |
| busy_n | output | 1 | Low while an operation, an error or an abort is pending |
| status_vis | output | 1 | High when `rd_data` carries status |
| st_done | output | 1 | Last operation finished without error |
| st_err | output | 1 | Program error held until abort |

## Verification
The assertions assume that `op_kind`, `op_addr` and the protection inputs carry known values whenever `op_valid` is high. They also assume that a drop is judged from the protection inputs as they stand at the request edge. The stimulus changes protection and override only at falling edges between operations. It never raises `op_valid` and `abort_req` together while the engine is idle, so each request is accepted or dropped purely on protection. Random programs mostly send data that is a subset of the stored word, and the rest deliberately provoke errors, so both completion paths recur.

// File: rtl/flash_exec_pkg.sv
package flash_exec_pkg;

   typedef enum logic [1:0] {
      OPK_PROG      = 2'd0,
      OPK_BLK_ERASE = 2'd1,
      OPK_ALL_ERASE = 2'd2,
      OPK_NOP       = 2'd3
   } op_kind_e;

   typedef enum logic [2:0] {
      ST_READ  = 3'd0,
      ST_PROG  = 3'd1,
      ST_ERASE = 3'd2,
      ST_ABORT = 3'd3,
      ST_FAULT = 3'd4
   } eng_state_e;

   localparam int STB_DONE  = 0;
   localparam int STB_ERR   = 1;
   localparam int STB_RUN   = 2;
   localparam int STB_ABORT = 3;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/flash_cycle_timer.sv
module flash_cycle_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/flash_prot_gate.sv
module flash_prot_gate #(
   parameter int NUM_BLOCKS = 4,
   parameter int BLK_W      = 2
) (
   input  logic [NUM_BLOCKS-1:0] prot_mask,
   input  logic                  unprot_all,
   input  logic [BLK_W-1:0]      blk_sel,
   output logic [NUM_BLOCKS-1:0] open_mask,
   output logic                  sel_open
);

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_open
      assign open_mask[b] = unprot_all | ~prot_mask[b];
   end

   assign sel_open = open_mask[blk_sel];

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array #(
   parameter int WORD_W        = 16,
   parameter int NUM_BLOCKS    = 4,
   parameter int WORDS_PER_BLK = 16,
   localparam int TOTAL        = NUM_BLOCKS * WORDS_PER_BLK,
   localparam int ADDR_W       = $clog2(TOTAL)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [WORD_W-1:0]     rd_word,
   input  logic [ADDR_W-1:0]     chk_addr,
   output logic [WORD_W-1:0]     chk_word,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [WORD_W-1:0]     wr_word,
   input  logic [NUM_BLOCKS-1:0] fill_mask,
   input  logic [WORD_W-1:0]     fill_word
);

   logic [TOTAL*WORD_W-1:0] flat_bus;

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
      logic [WORD_W-1:0] cells [WORDS_PER_BLK];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < WORDS_PER_BLK; w++) cells[w] <= '1;
         end else if (fill_mask[b]) begin
            for (int w = 0; w < WORDS_PER_BLK; w++) cells[w] <= fill_word;
         end else begin
            for (int w = 0; w < WORDS_PER_BLK; w++) begin
               if (wr_en && (wr_addr == ADDR_W'(b * WORDS_PER_BLK + w)))
                  cells[w] <= wr_word;
            end
         end
      end

      for (genvar w = 0; w < WORDS_PER_BLK; w++) begin : g_flat
         assign flat_bus[(b*WORDS_PER_BLK+w)*WORD_W +: WORD_W] = cells[w];
      end
   end

   assign rd_word  = flat_bus[rd_addr*WORD_W +: WORD_W];
   assign chk_word = flat_bus[chk_addr*WORD_W +: WORD_W];

endmodule

// File: rtl/flash_exec_engine.sv
module flash_exec_engine
   import flash_exec_pkg::*;
#(
   parameter int WORD_W        = 16,
   parameter int NUM_BLOCKS    = 4,
   parameter int WORDS_PER_BLK = 16,
   parameter int PROG_CYC      = 4,
   parameter int ERASE_CYC     = 24,
   parameter int ABORT_CYC     = 6,
   parameter logic [WORD_W-1:0] ABORT_FILL = '0,
   localparam int TOTAL  = NUM_BLOCKS * WORDS_PER_BLK,
   localparam int ADDR_W = $clog2(TOTAL),
   localparam int BLK_W  = $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  op_valid,
   input  logic [1:0]            op_kind,
   input  logic [ADDR_W-1:0]     op_addr,
   input  logic [WORD_W-1:0]     op_data,
   input  logic                  abort_req,
   input  logic [NUM_BLOCKS-1:0] prot_mask,
   input  logic                  unprot_all,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [WORD_W-1:0]     rd_data,
   output logic                  busy_n,
   output logic                  status_vis,
   output logic                  st_done,
   output logic                  st_err
);

   localparam int MAX_CYC = max3(PROG_CYC, ERASE_CYC, ABORT_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   // elaboration-time parameter checks
   if (NUM_BLOCKS < 2 || (1 << BLK_W) != NUM_BLOCKS) begin : g_bad_blocks
      $error("NUM_BLOCKS must be a power of two, at least 2");
   end
   if (WORDS_PER_BLK < 1 || (1 << $clog2(WORDS_PER_BLK)) != WORDS_PER_BLK) begin : g_bad_words
      $error("WORDS_PER_BLK must be a power of two");
   end
   if (WORD_W < 4) begin : g_bad_width
      $error("WORD_W must hold the four status bits");
   end
   if (PROG_CYC < 1 || ERASE_CYC < 1 || ABORT_CYC < 1) begin : g_bad_cyc
      $error("operation durations must be at least one cycle");
   end

   eng_state_e              state_q, state_d;
   logic [ADDR_W-1:0]       addr_q;
   logic [WORD_W-1:0]       data_q;
   logic [NUM_BLOCKS-1:0]   fill_q;
   logic                    done_q, err_q;

   op_kind_e                kind;
   logic [BLK_W-1:0]        req_blk;
   logic [NUM_BLOCKS-1:0]   open_mask;
   logic                    req_open;
   logic                    acc_prog, acc_blk, acc_all, accept;
   logic                    enter_abort;
   logic                    t_load, t_last;
   logic [CNT_W-1:0]        t_val;
   logic                    prog_fin, prog_bad, erase_fin, erase_cut;
   logic [WORD_W-1:0]       arr_word, chk_word, fill_word;
   logic [NUM_BLOCKS-1:0]   fill_now;
   logic [WORD_W-1:0]       status_w;

   assign kind    = op_kind_e'(op_kind);
   assign req_blk = op_addr[ADDR_W-1 -: BLK_W];

   flash_prot_gate #(
      .NUM_BLOCKS (NUM_BLOCKS),
      .BLK_W      (BLK_W)
   ) u_gate (
      .prot_mask  (prot_mask),
      .unprot_all (unprot_all),
      .blk_sel    (req_blk),
      .open_mask  (open_mask),
      .sel_open   (req_open)
   );

   always_comb begin
      logic idle_req;
      idle_req    = (state_q == ST_READ) && op_valid && !abort_req;
      acc_prog    = idle_req && (kind == OPK_PROG)      && req_open;
      acc_blk     = idle_req && (kind == OPK_BLK_ERASE) && req_open;
      acc_all     = idle_req && (kind == OPK_ALL_ERASE) && (|open_mask);
      accept      = acc_prog || acc_blk || acc_all;
      enter_abort = abort_req && ((state_q == ST_ERASE) || (state_q == ST_FAULT));
      t_load      = accept || enter_abort;
      if (enter_abort)   t_val = CNT_W'(ABORT_CYC);
      else if (acc_prog) t_val = CNT_W'(PROG_CYC);
      else               t_val = CNT_W'(ERASE_CYC);
   end

   flash_cycle_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .last     (t_last)
   );

   assign prog_fin  = (state_q == ST_PROG) && t_last;
   assign prog_bad  = |(data_q & ~chk_word);
   assign erase_cut = (state_q == ST_ERASE) && abort_req;
   assign erase_fin = (state_q == ST_ERASE) && t_last && !abort_req;
   assign fill_now  = (erase_fin || erase_cut) ? fill_q : '0;
   assign fill_word = erase_fin ? '1 : ABORT_FILL;

   flash_word_array #(
      .WORD_W        (WORD_W),
      .NUM_BLOCKS    (NUM_BLOCKS),
      .WORDS_PER_BLK (WORDS_PER_BLK)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_addr   (rd_addr),
      .rd_word   (arr_word),
      .chk_addr  (addr_q),
      .chk_word  (chk_word),
      .wr_en     (prog_fin),
      .wr_addr   (addr_q),
      .wr_word   (chk_word & data_q),
      .fill_mask (fill_now),
      .fill_word (fill_word)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_READ:  if (acc_prog) state_d = ST_PROG;
                   else if (acc_blk || acc_all) state_d = ST_ERASE;
         ST_PROG:  if (t_last) state_d = prog_bad ? ST_FAULT : ST_READ;
         ST_ERASE: if (abort_req) state_d = ST_ABORT;
                   else if (t_last) state_d = ST_READ;
         ST_ABORT: if (t_last) state_d = ST_READ;
         ST_FAULT: if (abort_req) state_d = ST_ABORT;
         default:  state_d = ST_READ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_READ;
         addr_q  <= '0;
         data_q  <= '0;
         fill_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q <= op_addr;
            data_q <= op_data;
            fill_q <= acc_all ? open_mask : (NUM_BLOCKS'(1) << req_blk);
         end
         if (accept || enter_abort || ((state_q == ST_READ) && abort_req))
            done_q <= 1'b0;
         else if ((prog_fin && !prog_bad) || erase_fin)
            done_q <= 1'b1;
         if (enter_abort)
            err_q <= 1'b0;
         else if (prog_fin && prog_bad)
            err_q <= 1'b1;
      end
   end

   always_comb begin
      status_w            = '0;
      status_w[STB_DONE]  = done_q;
      status_w[STB_ERR]   = err_q;
      status_w[STB_RUN]   = (state_q == ST_PROG) || (state_q == ST_ERASE);
      status_w[STB_ABORT] = (state_q == ST_ABORT);
   end

   assign busy_n     = (state_q == ST_READ);
   assign status_vis = (state_q != ST_READ);
   assign rd_data    = status_vis ? status_w : arr_word;
   assign st_done    = done_q;
   assign st_err     = err_q;

endmodule

// File: rtl/flash_exec_checker.sv
module flash_exec_checker
   import flash_exec_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int BLK_W      = 2,
   parameter int NUM_BLOCKS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  op_valid,
   input logic [1:0]            op_kind,
   input logic [ADDR_W-1:0]     op_addr,
   input logic                  abort_req,
   input logic [NUM_BLOCKS-1:0] prot_mask,
   input logic                  unprot_all,
   input logic                  busy_n,
   input logic                  status_vis,
   input logic                  st_done,
   input logic                  st_err,
   input eng_state_e            state,
   input logic                  t_last
);

   // R3: a program aimed at a protected block leaves the engine in read mode
   a_r3_prot_drop: assert property (@(posedge clk) disable iff (!rst_n)
      busy_n && op_valid && !abort_req && (op_kind == 2'd0) && !unprot_all
         && prot_mask[op_addr[ADDR_W-1 -: BLK_W]]
      |=> busy_n && !status_vis);

   // R6: a running program keeps going until its timer runs out
   a_r6_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROG) && !t_last |=> (state == ST_PROG));

   // R8: the error stays until an abort request
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      st_err && !abort_req |=> st_err);

   // R8: an error keeps busy low
   a_r8_err_busy: assert property (@(posedge clk) disable iff (!rst_n)
      st_err |-> !busy_n);

   // R5: done is only reported from read mode
   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      st_done |-> busy_n);

   // R10: an abort clears both status flags
   a_r10_abort_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ABORT) |-> !st_err && !st_done);

endmodule

bind flash_exec_engine flash_exec_checker #(
   .ADDR_W     (ADDR_W),
   .BLK_W      (BLK_W),
   .NUM_BLOCKS (NUM_BLOCKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_kind    (op_kind),
   .op_addr    (op_addr),
   .abort_req  (abort_req),
   .prot_mask  (prot_mask),
   .unprot_all (unprot_all),
   .busy_n     (busy_n),
   .status_vis (status_vis),
   .st_done    (st_done),
   .st_err     (st_err),
   .state      (state_q),
   .t_last     (t_last)
);

// File: tb/tb_flash_exec_engine.sv
`timescale 1ns/100ps
module tb_flash_exec_engine;

   localparam int WW    = 16;
   localparam int NB    = 4;
   localparam int WPB   = 16;
   localparam int TOT   = NB * WPB;
   localparam int AW    = 6;
   localparam int PCYC  = 4;
   localparam int ECYC  = 24;
   localparam int ACYC  = 6;
   localparam logic [WW-1:0] AFILL = 16'h0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [1:0]    op_kind = 2'd3;
   logic [AW-1:0] op_addr = '0;
   logic [WW-1:0] op_data = '0;
   logic          abort_req = 1'b0;
   logic [NB-1:0] prot_mask = '0;
   logic          unprot_all = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [WW-1:0] rd_data;
   logic          busy_n, status_vis, st_done, st_err;

   int n_vec = 0;
   int n_bad = 0;
   bit ended = 0;
   logic [WW-1:0] model [TOT];

   always #5 clk = ~clk;

   flash_exec_engine #(
      .WORD_W (WW), .NUM_BLOCKS (NB), .WORDS_PER_BLK (WPB),
      .PROG_CYC (PCYC), .ERASE_CYC (ECYC), .ABORT_CYC (ACYC), .ABORT_FILL (AFILL)
   ) dut (
      .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_kind (op_kind),
      .op_addr (op_addr), .op_data (op_data), .abort_req (abort_req),
      .prot_mask (prot_mask), .unprot_all (unprot_all), .rd_addr (rd_addr),
      .rd_data (rd_data), .busy_n (busy_n), .status_vis (status_vis),
      .st_done (st_done), .st_err (st_err)
   );

   function automatic bit blk_open(input int b);
      return unprot_all || !prot_mask[b];
   endfunction

   function automatic bit prog_err(input logic [WW-1:0] old, input logic [WW-1:0] d);
      return |(d & ~old);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   task automatic issue(input logic [1:0] k, input int a, input logic [WW-1:0] d);
      @(negedge clk);
      op_valid = 1'b1; op_kind = k; op_addr = AW'(a); op_data = d;
      @(negedge clk);
      op_valid = 1'b0; op_kind = 2'd3;
   endtask

   // counts falling edges with busy low, starting at the current one
   task automatic busy_span(input int cap, output int n);
      n = 0;
      while (!busy_n && n < cap) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_abort(output int n);
      @(negedge clk);
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      busy_span(ACYC + 10, n);
   endtask

   task automatic check_array(input string tag);
      @(negedge clk);
      #0.5;
      for (int i = 0; i < TOT; i++) begin
         rd_addr = AW'(i);
         #1;
         chk(tag, rd_data, model[i]);
      end
   endtask

   task automatic fill_block(input int b, input logic [WW-1:0] v);
      for (int w = 0; w < WPB; w++) model[b*WPB + w] = v;
   endtask

   // one program, checked against the model
   task automatic run_prog(input int a, input logic [WW-1:0] d);
      int n;
      logic [WW-1:0] old;
      bit bad;
      old = model[a];
      if (!blk_open(a / WPB)) begin
         issue(2'd0, a, d);
         chk("R3 drop busy_n", busy_n, 1'b1);
         chk("R3 drop status_vis", status_vis, 1'b0);
         chk("R3 drop err", st_err, 1'b0);
         return;
      end
      bad = prog_err(old, d);
      issue(2'd0, a, d);
      model[a] = old & d;
      if (!bad) begin
         busy_span(PCYC + 10, n);
         chk("R5 program length", n, PCYC);
         chk("R5 done", st_done, 1'b1);
      end else begin
         busy_span(PCYC + 8, n);
         chk("R8 busy held", n, PCYC + 8);
         chk("R8 err set", st_err, 1'b1);
         chk("R8 status word", rd_data, 16'h0002);
         do_abort(n);
         chk("R8 abort length", n, ACYC);
         chk("R8 err cleared", st_err, 1'b0);
      end
   endtask

   task automatic run_erase(input bit whole, input int a);
      int n;
      logic [NB-1:0] m;
      for (int b = 0; b < NB; b++)
         m[b] = whole ? blk_open(b) : ((b == a / WPB) && blk_open(b));
      issue(whole ? 2'd2 : 2'd1, a, '0);
      if (m == '0) begin
         chk("R3/R9 erase dropped", busy_n, 1'b1);
         return;
      end
      busy_span(ECYC + 10, n);
      chk("R5 erase length", n, ECYC);
      chk("R9 erase done", st_done, 1'b1);
      for (int b = 0; b < NB; b++) if (m[b]) fill_block(b, '1);
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      int n;
      void'($urandom(32'd20240611));
      for (int i = 0; i < TOT; i++) model[i] = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 busy_n", busy_n, 1'b1);
      chk("R1 status_vis", status_vis, 1'b0);
      chk("R1 done", st_done, 1'b0);
      chk("R1 err", st_err, 1'b0);
      check_array("R1 erased array");

      // R2, R5, R7: plain program, status word while running
      issue(2'd0, 5, 16'h1234);
      chk("R7 status_vis", status_vis, 1'b1);
      chk("R7 running status word", rd_data, 16'h0004);
      busy_span(PCYC + 10, n);
      chk("R5 program length", n, PCYC + 0);
      chk("R5 done", st_done, 1'b1);
      model[5] = 16'h1234;
      run_prog(5, 16'h1030);
      check_array("R2 AND result");

      // R6: abort and a new request during a program are ignored
      issue(2'd0, 40, 16'h00FF);
      abort_req = 1'b1; op_valid = 1'b1; op_kind = 2'd2;
      @(negedge clk);
      abort_req = 1'b0; op_valid = 1'b0; op_kind = 2'd3;
      busy_span(PCYC + 10, n);
      chk("R6 program length", n + 1, PCYC);
      chk("R6 done", st_done, 1'b1);
      model[40] = 16'h00FF;
      check_array("R6 no erase, program kept");

      // R8: program trying to set a cleared bit
      run_prog(5, 16'h0001);
      check_array("R8 stored AND");

      // R3 and R4: protection and override
      prot_mask = 4'b0010;
      run_prog(20, 16'h0F0F);
      run_erase(1'b0, 20);
      check_array("R3 protected unchanged");
      unprot_all = 1'b1;
      run_prog(20, 16'h0F0F);
      check_array("R4 override program");
      run_erase(1'b0, 20);
      check_array("R4 override erase");
      unprot_all = 1'b0;

      // R9: whole-array erase skips protected block
      prot_mask = 4'b0001;
      run_erase(1'b1, 0);
      check_array("R9 whole erase");
      prot_mask = 4'b1111;
      run_erase(1'b1, 0);
      prot_mask = 4'b0000;

      // R10: abort in the middle of a block erase
      run_prog(34, 16'h5555);
      issue(2'd1, 34, '0);
      repeat (4) @(negedge clk);
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      chk("R10 abort status word", rd_data, 16'h0008);
      busy_span(ACYC + 10, n);
      chk("R10 abort length", n, ACYC);
      chk("R10 done cleared", st_done, 1'b0);
      chk("R10 err clear", st_err, 1'b0);
      fill_block(2, AFILL);
      check_array("R10 invalid fill");

      // random mix
      for (int it = 0; it < 160; it++) begin
         int r, a;
         logic [WW-1:0] d;
         @(negedge clk);
         if (($urandom % 6) == 0) prot_mask = NB'($urandom);
         unprot_all = (($urandom % 5) == 0);
         r = $urandom % 10;
         a = $urandom % TOT;
         d = WW'($urandom);
         if (r < 7) run_prog(a, (($urandom % 4) == 0) ? d : (model[a] & d));
         else if (r < 9) run_erase(1'b0, a);
         else run_erase(1'b1, a);
         if ((it % 16) == 15) check_array("R2/R9 random model");
      end
      check_array("R2/R9 final model");
      finish_run();
   end

endmodule